// File: doc/BRIEF.md
# I2C Target Register-File Bridge

This block lets an I2C controller reach a small bank of 8-bit registers that lives outside it. It watches the SCL and SDA lines through synchronizers on a system clock that is much faster than SCL. It spots start, repeated-start and stop conditions and answers one fixed 7-bit device address. It returns data by pulling SDA low through an open-drain enable. SCL is never driven, so the target does not stretch the clock.

A write transfer carries the device address with a direction bit of 0. The byte after the address loads a register pointer. Each further byte is written to the register the pointer selects, and the pointer then steps by one. To read, the controller writes only the pointer byte, issues a repeated start, and sends the address again with a direction bit of 1. The pointer survives the repeated start. The target then shifts out registers from the pointer onward, one byte per acknowledge from the controller, until the controller answers with a not-acknowledge.

The register file is reached through a parallel port: an address, write data, a one-cycle write strobe, and read data. Read data is taken to be valid one system clock after the address, as from a registered block RAM.

Top module: `i2c_regfile_target`

## Requirements
- R1: After synchronous reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: After a start, an address byte whose upper seven bits equal `DEV_ADDR` (sent MSB first) is acknowledged. The target holds SDA low through the ninth SCL clock, whatever the direction bit (bit 0).
- R3: An address byte that does not match is not acknowledged. The bytes that follow it are neither acknowledged nor written until the next start or stop.
- R4: In a write transfer, the first byte after the address is acknowledged and loads the register pointer. Only its low `ADDR_W` bits are kept.
- R5: Every later byte of a write transfer is acknowledged and written with a single-cycle `reg_we` at the current `reg_addr`. The pointer then advances by one.
- R6: The pointer wraps modulo 2^`ADDR_W`, both during multi-byte writes and during multi-byte reads.
- R7: After a repeated start and an address byte with bit 0 set to 1, the target shifts out the register at the pointer kept from the earlier write, MSB first.
- R8: When the controller acknowledges a read byte, the pointer advances and the next register is shifted out. A not-acknowledge leaves the pointer unchanged.
- R9: On a not-acknowledge the target releases SDA and drives nothing more until the next start.
- R10: A start or stop that arrives before a byte's acknowledge clock aborts that byte, and no register is written. A start keeps the pointer.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_addr | output | ADDR_W | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents, valid one clock after `reg_addr` |

## Verification
The main function is exercised with several transfer patterns, and each one separates a different fault:
- A three-byte burst write at a mid-range pointer shows whether the strobe and the pointer step line up.
- A pointer byte with its upper bits set, followed by a write across the top register, separates truncation of the pointer from a missed wrap.
- A write followed by a repeated start and a three-byte read checks pointer retention. It also checks that the pointer advances on an acknowledge and holds on a not-acknowledge. The clock after the not-acknowledge reads 0xFF, which exposes any late drive of SDA.
- A wrong address, and bytes cut short by a stop or by a repeated start, must leave the register contents and the write count unchanged.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } tgt_state_e;

endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Bus lines idle high, so every stage resets to 1.
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '1;
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // Start and stop are SDA edges while SCL stays high on both samples.
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2C,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  tgt_state_e        state_q;
  logic [3:0]        cnt_q;
  logic              in_ack_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              bump_q;
  logic              oe_q;
  logic              we_q;
  logic [BYTE_W-1:0] wdata_q;

  logic rx_state;
  assign rx_state = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      bump_q   <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      we_q   <= 1'b0;
      bump_q <= 1'b0;
      // Pointer steps one cycle after the strobe, so the strobe sees the old pointer.
      if (bump_q) ptr_q <= ptr_q + 1'b1;

      if (start_ev) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_ev) begin
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && !in_ack_q && cnt_q < LAST_BIT) begin
          shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
          cnt_q   <= cnt_q + 4'd1;
        end else if (scl_fall && !in_ack_q && cnt_q == LAST_BIT) begin
          if (state_q == ST_ADDR && shreg_q[7:1] != DEV_ADDR) begin
            state_q <= ST_IGNORE;
          end else begin
            in_ack_q <= 1'b1;
            oe_q     <= 1'b1;
          end
        end else if (scl_rise && in_ack_q) begin
          // Commit happens only on the acknowledge clock.
          if (state_q == ST_PTR) begin
            ptr_q <= shreg_q[ADDR_W-1:0];
          end else if (state_q == ST_WDATA) begin
            we_q    <= 1'b1;
            wdata_q <= shreg_q;
            bump_q  <= 1'b1;
          end
        end else if (scl_fall && in_ack_q) begin
          in_ack_q <= 1'b0;
          cnt_q    <= '0;
          if (state_q == ST_ADDR && shreg_q[0]) begin
            state_q <= ST_RDATA;
            shreg_q <= reg_rdata;
            oe_q    <= ~reg_rdata[BYTE_W-1];
          end else begin
            oe_q <= 1'b0;
            if (state_q == ST_ADDR)     state_q <= ST_PTR;
            else if (state_q == ST_PTR) state_q <= ST_WDATA;
          end
        end
      end else if (state_q == ST_RDATA) begin
        if (scl_rise && !in_ack_q && cnt_q < LAST_BIT) begin
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall && !in_ack_q && cnt_q == LAST_BIT) begin
          oe_q     <= 1'b0;
          in_ack_q <= 1'b1;
        end else if (scl_fall && !in_ack_q && cnt_q != 4'd0) begin
          shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
          oe_q    <= ~shreg_q[BYTE_W-2];
        end else if (scl_rise && in_ack_q) begin
          if (sda_s) begin
            state_q  <= ST_IGNORE;
            in_ack_q <= 1'b0;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end else if (scl_fall && in_ack_q) begin
          in_ack_q <= 1'b0;
          cnt_q    <= '0;
          shreg_q  <= reg_rdata;
          oe_q     <= ~reg_rdata[BYTE_W-1];
        end
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;

  // R11: the drive only changes while SCL is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (oe_q != $past(oe_q)) |-> !$past(scl_s));

  // R5: write strobe lasts one cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    we_q |=> !we_q);

  // R5 / R6: pointer steps (modulo) right after each write
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    we_q |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

  // R5: writes originate only in the data phase of a write transfer
  p_we_origin_r5: assert property (@(posedge clk) disable iff (rst)
    we_q |-> ($past(state_q) == ST_WDATA));

  // R3 / R9: no drive while idle or ignoring the bus
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !oe_q);

  // R10: a start releases the line
  p_start_release_r10: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !oe_q);

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2C,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);

  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  i2c_line_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (line_s[1]),
    .sda_s    (line_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/test_i2c_regfile_target.sv
`timescale 1ns/1ps
module test_i2c_regfile_target;

  localparam logic [6:0] DEV  = 7'h2C;
  localparam int ADDR_W = 4;
  localparam int NREG   = 16;
  localparam int Q      = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic m_scl, m_sda;
  logic sda_line;
  logic sda_oe, reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [7:0] reg_wdata, rdata;

  assign sda_line = m_sda & ~sda_oe;

  i2c_regfile_target #(.DEV_ADDR(DEV), .ADDR_W(ADDR_W)) i_i2c_regfile_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(rdata)
  );

  // Register file model with registered read.
  logic [7:0] mem [NREG];
  int we_cnt, oe_bad;
  logic oe_prev;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'(8'h40 + i);
      we_cnt <= 0; oe_bad <= 0; oe_prev <= 1'b0;
    end else begin
      if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end
      oe_prev <= sda_oe;
      if (sda_oe != oe_prev && m_scl) oe_bad <= oe_bad + 1;
    end
    rdata <= mem[reg_addr];
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q_wait; repeat (Q) @(posedge clk); #1; endtask

  task automatic bus_start;
    m_sda = 1'b1; q_wait; m_scl = 1'b1; q_wait; m_sda = 1'b0; q_wait; m_scl = 1'b0; q_wait;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; q_wait; m_scl = 1'b1; q_wait; m_sda = 1'b1; q_wait;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; q_wait; m_scl = 1'b1; q_wait; q_wait; m_scl = 1'b0; q_wait;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; q_wait; m_scl = 1'b1; q_wait; ack = sda_line; q_wait; m_scl = 1'b0; q_wait;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q_wait; m_scl = 1'b1; q_wait; b[i] = sda_line; q_wait; m_scl = 1'b0;
    end
    q_wait; m_sda = nack; q_wait; m_scl = 1'b1; q_wait; q_wait; m_scl = 1'b0; q_wait;
    m_sda = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 reg_addr", reg_addr, 0);
  endtask

  task automatic t_write_burst;
    logic a; int w0;
    w0 = we_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, a); chk("R2 address ack", a, 0);
    send_byte(8'h03, a);       chk("R4 pointer ack", a, 0);
    send_byte(8'hA1, a);       chk("R5 data ack", a, 0);
    send_byte(8'hB2, a);
    send_byte(8'hC3, a);
    bus_stop;
    chk("R5 reg3", mem[3], 8'hA1);
    chk("R5 reg4", mem[4], 8'hB2);
    chk("R5 reg5", mem[5], 8'hC3);
    chk("R5 write count", we_cnt - w0, 3);
    chk("R5 pointer after burst", reg_addr, 6);
  endtask

  task automatic t_write_wrap;
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hFF, a);  // low 4 bits -> register 15
    send_byte(8'h5A, a);
    send_byte(8'h6B, a);
    bus_stop;
    chk("R4 truncated pointer reg15", mem[15], 8'h5A);
    chk("R6 wrap reg0", mem[0], 8'h6B);
    chk("R6 pointer after wrap", reg_addr, 1);
  endtask

  task automatic t_mismatch;
    logic a; int w0;
    w0 = we_cnt;
    bus_start;
    send_byte({7'h2D, 1'b0}, a); chk("R3 no address ack", a, 1);
    send_byte(8'h02, a);         chk("R3 no pointer ack", a, 1);
    send_byte(8'h77, a);         chk("R3 no data ack", a, 1);
    bus_stop;
    chk("R3 no write", we_cnt - w0, 0);
    chk("R3 reg2 kept", mem[2], 8'h42);
  endtask

  task automatic t_read_seq;
    logic a; logic [7:0] d;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h03, a);
    bus_start;
    send_byte({DEV, 1'b1}, a); chk("R7 read address ack", a, 0);
    recv_byte(1'b0, d);        chk("R7 first read byte", d, 8'hA1);
    recv_byte(1'b0, d);        chk("R8 second read byte", d, 8'hB2);
    recv_byte(1'b1, d);        chk("R8 third read byte", d, 8'hC3);
    chk("R9 released after nack", sda_oe, 0);
    recv_byte(1'b1, d);        chk("R9 no drive after nack", d, 8'hFF);
    bus_stop;
    chk("R8 pointer after reads", reg_addr, 5);
    chk("R11 drive changes with SCL high", oe_bad, 0);
  endtask

  task automatic t_read_wrap;
    logic a; logic [7:0] d;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h0F, a);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d); chk("R6 read reg15", d, 8'h5A);
    recv_byte(1'b1, d); chk("R6 read wraps to reg0", d, 8'h6B);
    bus_stop;
  endtask

  task automatic t_abort;
    logic a; logic [7:0] d; int w0;
    w0 = we_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h08, a);
    send_bits(8'hE7, 4);
    bus_stop;
    chk("R10 stop aborts byte", we_cnt - w0, 0);
    chk("R10 reg8 kept", mem[8], 8'h48);
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h09, a);
    send_bits(8'h3C, 5);
    bus_start;
    send_byte({DEV, 1'b1}, a); chk("R10 ack after restart", a, 0);
    recv_byte(1'b1, d);        chk("R10 pointer kept, reg9 unchanged", d, 8'h49);
    bus_stop;
    chk("R10 start aborts byte", we_cnt - w0, 0);
  endtask

  initial begin
    m_scl = 1'b1; m_sda = 1'b1; rst = 1'b1;
    repeat (5) @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;
    t_reset;
    t_write_burst;
    t_write_wrap;
    t_mismatch;
    t_read_seq;
    t_read_wrap;
    t_abort;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule